// File: doc/BRIEF.md
# Page Error Report Aggregator

This block sits behind a BCH decoder on the read path of a flash page. The decoder runs once per codeword and, for each one, presents a valid strobe, a corrected-bit count and a failure flag. The block folds these results into one 16-bit report word for the page. The first codeword has its own count and its own success bit. Every later codeword is merged into a second field, which holds the largest count seen, and into a second success bit, which drops on any failure.

A start pulse opens a page and programs how many codewords to expect. While the page is open, the block also watches every data byte read. The page-empty flag stays high only if every one of those bytes is 0xFF, which marks the page as erased. When the consumer sees this flag set, it disregards the report. One cycle after the last expected codeword is accepted, the block raises a done pulse for a single cycle. The report is final at that point.

Top module: `page_err_report`

## Requirements
- R1: After reset, and on the clock edge after `page_start`, `report` equals 16'h8080 (both counts 0, both OK bits set), `page_empty` is 1 and `report_done` is 0.
- R2: Bits 5:0 of `report` hold the corrected count of the first codeword of the page, saturated at 63.
- R3: Bit 7 of `report` is 1 exactly when the first codeword decoded without failure.
- R4: Bits 13:8 of `report` hold the maximum corrected count over codewords 2..N (saturated at 63). The field is not a sum, and it stays 0 when the page has a single codeword.
- R5: Bit 15 of `report` is 1 only if none of codewords 2..N flagged a failure. A single failure clears it for the rest of the page.
- R6: Bits 14 and 6 of `report` always read 0.
- R7: While a page is open, any `byte_valid` with `byte_data` other than 8'hFF clears `page_empty`. The flag stays cleared until the next `page_start`.
- R8: `report_done` is high for exactly one cycle, on the edge that accepts the `cw_total`-th codeword. `report` holds its final value in that same cycle.
- R9: Codewords and bytes presented while no page is open (before the first start, or after done) change neither `report` nor `page_empty`, and they raise no done pulse.
- R10: A codeword presented in the same cycle as `page_start` is dropped, because the start takes priority.
- R11: A `page_start` with `cw_total` of 0 raises `report_done` on the following edge, with the cleared report of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_start | input | 1 | Opens a page and clears the report |
| cw_total | input | CW_W | Number of codewords in the page, sampled with `page_start` |
| cw_valid | input | 1 | Decoder result strobe |
| cw_errs | input | ERR_W | Corrected bit count of the codeword |
| cw_fail | input | 1 | Codeword could not be corrected |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte read from the page |
| report | output | 16 | Error report word |
| page_empty | output | 1 | Every byte of the page was 0xFF |
| report_done | output | 1 | One-cycle pulse when the report is complete |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Counts above 63:** a design without saturation would wrap to a small value.
- **Large first count and later failures:** a design that merges the first codeword into the second field would show it in bits 13:8, or would clear bit 15 on a failure of the first codeword.
- **Falling counts on later codewords:** a design that sums or keeps the last count instead of the maximum would give a different value in bits 13:8.
- **Single-codeword pages:** the second field and bit 15 must stay at their cleared values.
- **Codewords after done, and a codeword in the same cycle as start:** a design that accepts either would change the report.
- **Erased pages with one late non-0xFF byte:** a design that does not hold the empty flag low would report an erased page.
- **A zero codeword count:** a design that does not handle it would never finish the page.

// File: rtl/page_err_report.sv
module page_err_report #(
  parameter int ERR_W = 8,
  parameter int CW_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             page_start,
  input  logic [CW_W-1:0]  cw_total,
  input  logic             cw_valid,
  input  logic [ERR_W-1:0] cw_errs,
  input  logic             cw_fail,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic [15:0]      report,
  output logic             page_empty,
  output logic             report_done
);
  localparam int FLD_W = 6;
  localparam logic [FLD_W-1:0] FLD_MAX = '1;

  logic            active;
  logic [CW_W-1:0] idx, total;
  logic [FLD_W-1:0] cnt0, maxn, sat;
  logic            ok0, okn, empty, done;
  logic            last;

  assign sat  = (cw_errs > ERR_W'(FLD_MAX)) ? FLD_MAX : cw_errs[FLD_W-1:0];
  assign last = ({1'b0, idx} + 1'b1) == {1'b0, total};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      total  <= '0;
      cnt0   <= '0;
      maxn   <= '0;
      ok0    <= 1'b1;
      okn    <= 1'b1;
      empty  <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (page_start) begin
        active <= (cw_total != '0);
        idx    <= '0;
        total  <= cw_total;
        cnt0   <= '0;
        maxn   <= '0;
        ok0    <= 1'b1;
        okn    <= 1'b1;
        empty  <= 1'b1;
        done   <= (cw_total == '0);
      end else if (active) begin
        if (byte_valid && byte_data != 8'hFF) empty <= 1'b0;
        if (cw_valid) begin
          if (idx == '0) begin
            cnt0 <= sat;
            ok0  <= ~cw_fail;
          end else begin
            if (sat > maxn) maxn <= sat;
            if (cw_fail) okn <= 1'b0;
          end
          idx <= idx + 1'b1;
          if (last) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      end
    end
  end

  assign report      = {okn, 1'b0, maxn, ok0, 1'b0, cnt0};
  assign page_empty  = empty;
  assign report_done = done;

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_start |=> (report == 16'h8080 && page_empty));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (report_done && !page_start) |=> !report_done);
  // R4
  max_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_start |=> report[13:8] >= $past(report[13:8]));
  // R5
  okn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_start && !report[15]) |=> !report[15]);
  // R7
  empty_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_start && !page_empty) |=> !page_empty);
  // R9
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_start && !cw_valid) |=> $stable(report));
endmodule

// File: tb/sim_page_err_report.sv
module sim_page_err_report;
  logic clk = 0, rst_n = 0, page_start = 0, cw_valid = 0, cw_fail = 0, byte_valid = 0;
  logic [7:0] cw_total = 0, cw_errs = 0, byte_data = 0;
  logic [15:0] report;
  logic page_empty, report_done;
  int n_chk = 0, n_bad = 0;
  logic [5:0] m_c0, m_mx;
  logic m_ok0, m_okn, m_emp;
  int m_idx;

  page_err_report u0 (.*);

  always #5 clk = ~clk;

  function automatic logic [5:0] sat6(input int e);
    return (e > 63) ? 6'd63 : e[5:0];
  endfunction

  function automatic logic [15:0] build(input logic [5:0] c0, input logic [5:0] mx,
                                        input logic o0, input logic on);
    return {on, 1'b0, mx, o0, 1'b0, c0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic start(input int n, input bit with_cw);
    page_start = 1; cw_total = n[7:0];
    cw_valid = with_cw; cw_errs = 8'd50; cw_fail = 1;
    tick();
    page_start = 0; cw_valid = 0; cw_fail = 0;
    m_c0 = 0; m_mx = 0; m_ok0 = 1; m_okn = 1; m_emp = 1; m_idx = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit track);
    byte_valid = 1; byte_data = b;
    tick();
    byte_valid = 0;
    if (track && b != 8'hFF) m_emp = 0;
  endtask

  task automatic send_cw(input int e, input bit f, input bit track);
    cw_valid = 1; cw_errs = e[7:0]; cw_fail = f;
    tick();
    cw_valid = 0; cw_fail = 0;
    if (track) begin
      if (m_idx == 0) begin m_c0 = sat6(e); m_ok0 = !f; end
      else begin if (sat6(e) > m_mx) m_mx = sat6(e); if (f) m_okn = 0; end
      m_idx++;
    end
  endtask

  task automatic check_final(input string tag);
    check({tag, " R8 done"}, report_done, 1);
    check({tag, " R2 R3 R4 R5 R6 report"}, report, build(m_c0, m_mx, m_ok0, m_okn));
    check({tag, " R7 empty"}, page_empty, m_emp);
    tick();
    check({tag, " R8 one-cycle"}, report_done, 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R1 reset report", report, 16'h8080);
    check("R1 reset empty", page_empty, 1);
    check("R1 reset done", report_done, 0);

    // R9: traffic before any page
    send_cw(40, 1, 0);
    send_byte(8'h00, 0);
    check("R9 idle report", report, 16'h8080);
    check("R9 idle empty", page_empty, 1);
    check("R9 idle done", report_done, 0);

    // R10: codeword with start is dropped
    start(3, 1);
    check("R10 start wins", report, 16'h8080);
    // R2 R4 R5 directed: saturation, falling counts, later failure
    send_cw(100, 0, 1);
    check("R2 saturate", report[5:0], 63);
    send_cw(70, 1, 1);
    send_cw(5, 0, 1);
    check_final("dir1");

    // R9: after done
    send_cw(9, 1, 0);
    send_byte(8'h12, 0);
    check("R9 post-done report", report, build(m_c0, m_mx, m_ok0, m_okn));
    check("R9 post-done empty", page_empty, 1);

    // R4 single codeword page, first fails (R3)
    start(1, 0);
    send_byte(8'hFF, 1);
    send_cw(12, 1, 1);
    check_final("single");

    // R11 zero count
    start(0, 0);
    check("R11 done", report_done, 1);
    check("R11 report", report, 16'h8080);

    // R7 late non-FF byte
    start(2, 0);
    send_byte(8'hFF, 1);
    send_cw(3, 0, 1);
    send_byte(8'hFE, 1);
    send_byte(8'hFF, 1);
    send_cw(4, 0, 1);
    check_final("late-byte");

    // random pages
    for (int p = 0; p < 40; p++) begin
      int n = 1 + $urandom % 6;
      bit erased = ($urandom % 3) == 0;
      start(n, 0);
      for (int c = 0; c < n; c++) begin
        int nb = $urandom % 4;
        for (int b = 0; b < nb; b++)
          send_byte((erased || ($urandom % 10) != 0) ? 8'hFF : 8'($urandom), 1);
        send_cw($urandom % 90, ($urandom % 8) == 0, 1);
        if (c < n - 1) check("R8 no early done", report_done, 0);
      end
      check_final("rand");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule